// File: doc/BRIEF.md
# I2C Slave Receive Byte Buffer

This block sits between the bit engine of an I2C slave and the CPU on the receive side. Every byte the bit engine finishes arrives as a one-cycle pulse with its data. The block keeps up to two bytes in a small FIFO. The CPU drains the FIFO one byte per read strobe. The oldest byte is always shown on the read-data output, and an empty flag tells the CPU when nothing is left.

A new write-direction address match does not discard anything, so bytes left over from an earlier transfer can still be read after a fresh START. If a byte completes while both FIFO slots are occupied, the block parks it in a single holding stage and raises a sticky write-event interrupt. It also asks the bit engine to hold SCL low. When a CPU read frees a slot, the parked byte moves into the FIFO and the stretch request drops.

Top module: `i2c_rx_buffer`

## Requirements
- R1: After reset, rx_empty is 1 and both irq and stretch are 0.
- R2: A byte_done pulse that arrives while fewer than two bytes are stored is stored in the FIFO. From the next cycle rx_empty is 0, and rd_data shows the oldest stored byte.
- R3: Each rd_strobe while the FIFO is non-empty removes the oldest byte. rx_empty returns to 1 once the last byte is removed. An rd_strobe while the FIFO is empty changes nothing.
- R4: addr_wr_match has no effect on the stored bytes, on rd_data or on rx_empty.
- R5: A byte_done pulse that arrives while two bytes are stored and the holding stage is free sets irq. If no byte is removed in the same cycle, the byte is parked in the holding stage and stretch is 1 from the next cycle.
- R6: An rd_strobe while a byte is parked removes the oldest byte and moves the parked byte to the tail of the FIFO. stretch is 0 from the next cycle and two bytes remain stored.
- R7: A byte_done pulse while stretch is 1 is ignored. The parked byte and the FIFO contents are unchanged.
- R8: irq stays 1 until an irq_clr strobe. If a set condition and irq_clr fall in the same cycle, irq is 1 afterwards.
- R9: A byte_done and an rd_strobe in the same cycle lose neither byte: the oldest leaves and the new byte enters in arrival order. When this happens with two bytes stored, irq is still set, but nothing is parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_done | input | 1 | One-cycle pulse: a received byte is complete |
| byte_data | input | W | Byte accompanying byte_done |
| addr_wr_match | input | 1 | Pulse: own address matched with write direction |
| rd_strobe | input | 1 | CPU read of the data-in register (pops one byte) |
| irq_clr | input | 1 | CPU strobe clearing the write-event interrupt |
| rd_data | output | W | Oldest stored byte |
| rx_empty | output | 1 | 1 when no byte is stored |
| irq | output | 1 | Sticky write-event interrupt request |
| stretch | output | 1 | Request to hold SCL low while a byte is parked |

## Verification
Two collisions matter most. The first is a CPU pop landing in the same cycle as a byte completion. The second is a pop landing on a cycle where a byte is already parked, which may coincide with a byte completion that must then be ignored. The bench preloads the buffer with zero to three bytes, so that every state from empty to full-with-parked-byte is covered. It then applies every combination of the four input strobes over two consecutive cycles. After each cycle it compares rd_data, rx_empty, irq and stretch against a queue model built from the requirements. Each byte carries a distinct running value, so a byte that is lost or reordered in a collision shows up as a wrong rd_data.

// File: rtl/i2c_rx_buffer.sv
module i2c_rx_buffer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         byte_done,
  input  logic [W-1:0] byte_data,
  input  logic         addr_wr_match,
  input  logic         rd_strobe,
  input  logic         irq_clr,
  output logic [W-1:0] rd_data,
  output logic         rx_empty,
  output logic         irq,
  output logic         stretch
);

  logic [W-1:0] s0, s1, hd;
  logic [1:0]   cnt;
  logic         hv, irq_q;

  logic [W-1:0] s0_n, s1_n, hd_n, in_d;
  logic [1:0]   cnt_n, ca;
  logic         hv_n, irq_n, in_v;

  wire full = (cnt == 2'd2);
  wire pop  = rd_strobe && (cnt != 2'd0);
  wire take = byte_done && !hv;

  always_comb begin
    ca    = cnt - {1'b0, pop};
    s0_n  = pop ? s1 : s0;
    s1_n  = s1;
    in_v  = hv ? pop : (take && (!full || pop));
    in_d  = hv ? hd : byte_data;
    if (in_v) begin
      if (ca == 2'd0) s0_n = in_d;
      else            s1_n = in_d;
    end
    cnt_n = ca + {1'b0, in_v};
    hv_n  = hv ? !pop : (take && full && !pop);
    hd_n  = (take && full && !pop) ? byte_data : hd;
    irq_n = (take && full) ? 1'b1 : (irq_clr ? 1'b0 : irq_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s0    <= '0;
      s1    <= '0;
      hd    <= '0;
      cnt   <= 2'd0;
      hv    <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      s0    <= s0_n;
      s1    <= s1_n;
      hd    <= hd_n;
      cnt   <= cnt_n;
      hv    <= hv_n;
      irq_q <= irq_n;
    end
  end

  assign rd_data  = s0;
  assign rx_empty = (cnt == 2'd0);
  assign irq      = irq_q;
  assign stretch  = hv;

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 2'd2);

  a_r5_park_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    stretch |-> !rx_empty && cnt == 2'd2);

  a_r5_irq_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && full && !stretch |=> irq);

  a_r4_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr_match && !byte_done && !rd_strobe |=> $stable(cnt) && $stable(rd_data));

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    stretch && rd_strobe |=> !stretch && cnt == 2'd2);

  a_r7_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    stretch && byte_done && !rd_strobe |=> stretch && $stable(hd) && $stable(rd_data));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);

  a_r3_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty && rd_strobe && !byte_done |=> rx_empty);

endmodule

// File: tb/test_i2c_rx_buffer.sv
module test_i2c_rx_buffer;
  localparam int W = 8;
  localparam time TCLK = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         byte_done = 1'b0, addr_wr_match = 1'b0, rd_strobe = 1'b0, irq_clr = 1'b0;
  logic [W-1:0] byte_data = '0;
  logic [W-1:0] rd_data;
  logic         rx_empty, irq, stretch;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] mq [0:1];
  int           mc;
  logic         mh, mi;
  logic [W-1:0] mhd;
  logic [W-1:0] seq_val = 8'h01;

  always #(TCLK/2) clk = ~clk;

  i2c_rx_buffer #(.W(W)) i_i2c_rx_buffer (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_data(byte_data),
    .addr_wr_match(addr_wr_match), .rd_strobe(rd_strobe), .irq_clr(irq_clr),
    .rd_data(rd_data), .rx_empty(rx_empty), .irq(irq), .stretch(stretch));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "rx_empty", int'(rx_empty), int'(mc == 0));
    chk(tag, "irq", int'(irq), int'(mi));
    chk(tag, "stretch", int'(stretch), int'(mh));
    if (mc != 0) chk(tag, "rd_data", int'(rd_data), int'(mq[0]));
  endtask

  task automatic model_push(input logic [W-1:0] d);
    if (mc == 0) mq[0] = d; else mq[1] = d;
    mc++;
  endtask

  task automatic model_pop();
    mq[0] = mq[1];
    mc--;
  endtask

  task automatic step(input logic bd, input logic rd, input logic aw, input logic clr);
    string tag;
    logic  pop, full, was_h;
    pop = rd && (mc > 0);
    full = (mc == 2);
    was_h = mh;
    if (rd && bd && !mh)      tag = "R9";
    else if (bd && mh)        tag = "R7";
    else if (rd && mh)        tag = "R6";
    else if (bd && full)      tag = "R5";
    else if (clr)             tag = "R8";
    else if (aw)              tag = "R4";
    else if (rd)              tag = "R3";
    else if (bd)              tag = "R2";
    else                      tag = "R8";
    byte_done = bd; rd_strobe = rd; addr_wr_match = aw; irq_clr = clr;
    byte_data = seq_val;
    if (was_h) begin
      if (pop) begin model_pop(); model_push(mhd); mh = 1'b0; end
    end else begin
      if (bd && full) mi = 1'b1;
      else if (clr)   mi = 1'b0;
      if (pop) model_pop();
      if (bd) begin
        if (full && !pop) begin mh = 1'b1; mhd = seq_val; end
        else model_push(seq_val);
      end
    end
    if (was_h && clr) mi = 1'b0;
    if (bd) seq_val = seq_val + 8'h01;
    @(negedge clk);
    byte_done = 1'b0; rd_strobe = 1'b0; addr_wr_match = 1'b0; irq_clr = 1'b0;
    compare(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    byte_done = 1'b0; rd_strobe = 1'b0; addr_wr_match = 1'b0; irq_clr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    mc = 0; mh = 1'b0; mi = 1'b0; mhd = '0;
    mq[0] = '0; mq[1] = '0;
    compare("R1");
  endtask

  initial begin
    #(TCLK * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    for (int pre = 0; pre < 4; pre++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          do_reset();
          for (int k = 0; k < pre; k++) step(1'b1, 1'b0, 1'b0, 1'b0);
          step(a[0], a[1], a[2], a[3]);
          step(b[0], b[1], b[2], b[3]);
          for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 1'b0, 1'b0);
        end
      end
    end
    do_reset();
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 1'b0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule